// File: doc/BRIEF.md
# Serial Port Transmit/Receive Queue with Packed Holding-Register Writes

This block sits between a bus-facing holding register and the serial shifters of a UART-style port. Software or a DMA engine writes characters into the holding register. When queue mode is on, a word-wide write carries four characters and an 8-bit write carries one. The characters wait in a byte queue, and the transmit shifter drains them through a valid/ready pop interface. A level-sensitive transmit request tells a DMA engine when the queue has room. A programmable ready mode sets whether one free slot is enough or four are needed, so that every DMA beat can be a full 32-bit write.

A matching receive queue takes characters from the receive shifter. It raises a receive request when enough characters are waiting: one or four, as the receive ready mode selects. A flush input empties the transmit queue and a clear input empties the receive queue. When queue mode is off, both sides act as plain one-character holding registers and the ready modes have no effect.

Top module: `txf_serial_fifo`

## Requirements
- R1: After reset both levels are 0, queue mode is off, both ready modes read ONE (0), the overflow flag is 0, `tx_req` is 1, `rx_req` is 0 and both pop valids are 0.
- R2: In queue mode, an 8-bit holding write (`thr_word`=0) adds one character, `thr_data[7:0]`, and `tx_level` rises by one on the next cycle.
- R3: In queue mode, a 32-bit holding write (`thr_word`=1) adds four characters, which later pop in the order bits [7:0], [15:8], [23:16], [31:24].
- R4: A write that does not fit is dropped whole. A 32-bit write fails when fewer than four slots are free, and an 8-bit write fails when the queue is full. A dropped write sets `tx_overflow`, which stays set until a transmit flush.
- R5: In queue mode with the transmit ready mode at FOUR (1), `tx_req` is high exactly when at least four slots are free. With the mode at ONE (0), it is high exactly when at least one slot is free.
- R6: With queue mode off, each side holds at most one character. A holding write of either width stores only `thr_data[7:0]`. `tx_req` is high exactly when the transmit side is empty, whatever the ready mode.
- R7: In queue mode, `rx_req` is high exactly when `rx_level` is at least 1 (receive mode ONE, 0) or at least 4 (receive mode FOUR, 1). With queue mode off it is high exactly when a character is held.
- R8: `tx_flush` empties the transmit queue and clears `tx_overflow` on the next cycle, and a holding write in the same cycle is discarded. `rx_clear` empties the receive queue, and a receive push in the same cycle is discarded.
- R9: On each pop side, one character leaves per cycle in which valid and ready are both high, in arrival order. A pop and a push in the same cycle leave the level unchanged for a one-character push.
- R10: A cycle with `cfg_we` high loads the queue-mode enable and both ready-mode fields. The new values appear on the `mode_*` outputs on the next cycle.
- R11: A receive character that arrives when the receive side is at capacity is dropped, and the held contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the mode register |
| cfg_fifo_en | input | 1 | Queue mode enable value to load |
| cfg_tx_four | input | 1 | Transmit ready mode to load (0 ONE, 1 FOUR) |
| cfg_rx_four | input | 1 | Receive ready mode to load (0 ONE, 1 FOUR) |
| mode_fifo_en | output | 1 | Current queue mode enable |
| mode_tx_four | output | 1 | Current transmit ready mode |
| mode_rx_four | output | 1 | Current receive ready mode |
| thr_we | input | 1 | Holding register write strobe |
| thr_word | input | 1 | 1: 32-bit write, 0: 8-bit write |
| thr_data | input | 32 | Holding register write data |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_overflow | output | 1 | Sticky dropped-write flag |
| tx_level | output | $clog2(DEPTH+1) | Transmit queue occupancy |
| tx_req | output | 1 | Transmit DMA request |
| tx_valid | output | 1 | Transmit character available |
| tx_ready | input | 1 | Shifter takes the character |
| tx_data | output | 8 | Transmit head character |
| rx_in_valid | input | 1 | Received character strobe |
| rx_in_data | input | 8 | Received character |
| rx_clear | input | 1 | Empty the receive queue |
| rx_level | output | $clog2(DEPTH+1) | Receive queue occupancy |
| rx_req | output | 1 | Receive DMA request |
| rx_valid | output | 1 | Receive character available |
| rx_ready | input | 1 | Reader takes the character |
| rx_data | output | 8 | Receive head character |

## Verification
The hardest case to reach is a queue that is nearly full but not quite, with between one and three free slots. In that state a word write must be dropped while byte writes still fit, and the FOUR-mode request is already low. The stimulus table reaches it with three word writes and one byte write, tries a word that must bounce, and then fills the last slots one byte at a time. Pops then step the level back across the four-free boundary and check the order of the bytes within each word.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic {
        RDY_ONE  = 1'b0,
        RDY_FOUR = 1'b1
    } rdy_mode_e;

    typedef struct packed {
        logic      fifo_en;
        rdy_mode_e tx_mode;
        rdy_mode_e rx_mode;
    } mode_cfg_t;

    localparam int LANES = 4;

    function automatic logic [2:0] rdy_need(input rdy_mode_e m);
        return (m == RDY_FOUR) ? 3'd4 : 3'd1;
    endfunction

endpackage

// File: rtl/txf_byte_queue.sv
module txf_byte_queue #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level
);
    import txf_pkg::*;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt;
    logic          pop_ok;

    assign pop_ok = pop && (cnt != '0) && !clr;

    always_ff @(posedge clk) begin
        if (!clr) begin
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < push_n)
                    mem[wr_ptr + PW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_ok);
            cnt    <= cnt + LW'(push_n) - LW'(pop_ok);
        end
    end

    assign head  = mem[rd_ptr];
    assign level = cnt;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= LW'(DEPTH));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    a_r9_single_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && push_n == 3'd0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/txf_admit.sv
module txf_admit #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          we,
    input  logic          word,
    input  logic [31:0]   data,
    input  logic          flush,
    input  logic [LW-1:0] level,
    output logic [2:0]    push_n,
    output logic [31:0]   push_data,
    output logic          drop
);
    logic [LW-1:0] cap, room;
    logic [2:0]    need;

    always_comb begin
        cap       = fifo_en ? LW'(DEPTH) : LW'(1);
        room      = (level >= cap) ? '0 : cap - level;
        need      = (fifo_en && word) ? 3'd4 : 3'd1;
        push_data = fifo_en ? data : {24'd0, data[7:0]};
        push_n    = 3'd0;
        drop      = 1'b0;
        if (!flush && we) begin
            if (room >= LW'(need)) push_n = need;
            else                   drop   = 1'b1;
        end
    end

    a_r4_all_or_nothing: assert property (@(posedge clk) disable iff (rst)
        (push_n == 3'd0) || (push_n == 3'd1) || (push_n == 3'd4));
    a_r6_single_one_char: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (push_n <= 3'd1));

endmodule

// File: rtl/txf_ready_gen.sv
module txf_ready_gen #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              fifo_en,
    input  txf_pkg::rdy_mode_e mode,
    input  logic [LW-1:0]     amount,
    input  logic              single_ok,
    output logic              req
);
    import txf_pkg::*;

    always_comb begin
        if (fifo_en) req = (amount >= LW'(rdy_need(mode)));
        else         req = single_ok;
    end

endmodule

// File: rtl/txf_serial_fifo.sv
module txf_serial_fifo #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic          cfg_tx_four,
    input  logic          cfg_rx_four,
    output logic          mode_fifo_en,
    output logic          mode_tx_four,
    output logic          mode_rx_four,
    input  logic          thr_we,
    input  logic          thr_word,
    input  logic [31:0]   thr_data,
    input  logic          tx_flush,
    output logic          tx_overflow,
    output logic [LW-1:0] tx_level,
    output logic          tx_req,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    input  logic          rx_in_valid,
    input  logic [7:0]    rx_in_data,
    input  logic          rx_clear,
    output logic [LW-1:0] rx_level,
    output logic          rx_req,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [7:0]    rx_data
);
    import txf_pkg::*;

    mode_cfg_t     cfg_q;
    logic          ovf_q;
    logic [2:0]    tx_push_n, rx_push_n;
    logic [31:0]   tx_push_data, rx_push_data;
    logic          tx_drop, rx_drop;
    logic [LW-1:0] tx_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{fifo_en: 1'b0, tx_mode: RDY_ONE, rx_mode: RDY_ONE};
        end else if (cfg_we) begin
            cfg_q.fifo_en <= cfg_fifo_en;
            cfg_q.tx_mode <= rdy_mode_e'(cfg_tx_four);
            cfg_q.rx_mode <= rdy_mode_e'(cfg_rx_four);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || tx_flush) ovf_q <= 1'b0;
        else if (tx_drop)    ovf_q <= 1'b1;
    end

    txf_admit #(.DEPTH(DEPTH)) u_tx_admit (
        .clk(clk), .rst(rst), .fifo_en(cfg_q.fifo_en), .we(thr_we),
        .word(thr_word), .data(thr_data), .flush(tx_flush), .level(tx_level),
        .push_n(tx_push_n), .push_data(tx_push_data), .drop(tx_drop)
    );

    txf_byte_queue #(.DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .clr(tx_flush), .push_n(tx_push_n),
        .push_data(tx_push_data), .pop(tx_ready), .head(tx_data), .level(tx_level)
    );

    txf_admit #(.DEPTH(DEPTH)) u_rx_admit (
        .clk(clk), .rst(rst), .fifo_en(cfg_q.fifo_en), .we(rx_in_valid),
        .word(1'b0), .data({24'd0, rx_in_data}), .flush(rx_clear), .level(rx_level),
        .push_n(rx_push_n), .push_data(rx_push_data), .drop(rx_drop)
    );

    txf_byte_queue #(.DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .clr(rx_clear), .push_n(rx_push_n),
        .push_data(rx_push_data), .pop(rx_ready), .head(rx_data), .level(rx_level)
    );

    assign tx_free = (tx_level >= LW'(DEPTH)) ? '0 : LW'(DEPTH) - tx_level;

    txf_ready_gen #(.DEPTH(DEPTH)) u_tx_rdy (
        .fifo_en(cfg_q.fifo_en), .mode(cfg_q.tx_mode), .amount(tx_free),
        .single_ok(tx_level == '0), .req(tx_req)
    );

    txf_ready_gen #(.DEPTH(DEPTH)) u_rx_rdy (
        .fifo_en(cfg_q.fifo_en), .mode(cfg_q.rx_mode), .amount(rx_level),
        .single_ok(rx_level != '0), .req(rx_req)
    );

    assign mode_fifo_en = cfg_q.fifo_en;
    assign mode_tx_four = cfg_q.tx_mode;
    assign mode_rx_four = cfg_q.rx_mode;
    assign tx_overflow  = ovf_q;
    assign tx_valid     = (tx_level != '0);
    assign rx_valid     = (rx_level != '0);

    a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (tx_overflow && !tx_flush) |=> tx_overflow);
    a_r5_four_needs_room: assert property (@(posedge clk) disable iff (rst)
        (mode_fifo_en && mode_tx_four && tx_req) |-> (LW'(DEPTH) - tx_level >= LW'(4)));
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (mode_fifo_en == $past(cfg_fifo_en)));
    a_r11_rx_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        rx_drop |=> (rx_level == $past(rx_level) - LW'($past(rx_valid && rx_ready))));

endmodule

// File: tb/tb_txf_serial_fifo.sv
module tb_txf_serial_fifo;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, cfg_we, cfg_fifo_en, cfg_tx_four, cfg_rx_four;
    logic mode_fifo_en, mode_tx_four, mode_rx_four;
    logic thr_we, thr_word, tx_flush, tx_overflow, tx_req, tx_valid, tx_ready;
    logic [31:0] thr_data;
    logic [LW-1:0] tx_level, rx_level;
    logic [7:0] tx_data, rx_in_data, rx_data;
    logic rx_in_valid, rx_clear, rx_req, rx_valid, rx_ready;

    txf_serial_fifo #(.DEPTH(DEPTH)) dut (.*);

    int nchk = 0, nfail = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] d;
        logic [4:0]  lvl;
        logic        req;
        logic        ovf;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 32'h44332211, 5'd4,  1'b1, 1'b0},
        '{2'd1, 32'h88776655, 5'd8,  1'b1, 1'b0},
        '{2'd1, 32'hCCBBAA99, 5'd12, 1'b1, 1'b0},
        '{2'd0, 32'h000000DD, 5'd13, 1'b0, 1'b0},
        '{2'd1, 32'h11111111, 5'd13, 1'b0, 1'b1},
        '{2'd0, 32'h000000EE, 5'd14, 1'b0, 1'b1},
        '{2'd0, 32'h000000F0, 5'd15, 1'b0, 1'b1},
        '{2'd0, 32'h000000F1, 5'd16, 1'b0, 1'b1},
        '{2'd0, 32'h000000F2, 5'd16, 1'b0, 1'b1},
        '{2'd2, 32'h00000011, 5'd15, 1'b0, 1'b1},
        '{2'd2, 32'h00000022, 5'd14, 1'b0, 1'b1},
        '{2'd2, 32'h00000033, 5'd13, 1'b0, 1'b1},
        '{2'd2, 32'h00000044, 5'd12, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; thr_we = 0; tx_flush = 0; tx_ready = 0;
        rx_in_valid = 0; rx_clear = 0; rx_ready = 0;
    endtask

    task automatic cfg(input logic f, input logic t4, input logic r4);
        cfg_we = 1; cfg_fifo_en = f; cfg_tx_four = t4; cfg_rx_four = r4;
        tick();
        chk("R10 mode readback", {mode_fifo_en, mode_tx_four, mode_rx_four}, {f, t4, r4});
    endtask

    task automatic wr(input logic w, input logic [31:0] d);
        thr_we = 1; thr_word = w; thr_data = d;
        tick();
    endtask

    task automatic rxpush(input logic [7:0] d);
        rx_in_valid = 1; rx_in_data = d;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_fifo_en = 0; cfg_tx_four = 0; cfg_rx_four = 0;
        thr_we = 0; thr_word = 0; thr_data = 0; tx_flush = 0; tx_ready = 0;
        rx_in_valid = 0; rx_in_data = 0; rx_clear = 0; rx_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 modes", {mode_fifo_en, mode_tx_four, mode_rx_four}, 0);
        chk("R1 overflow", 32'(tx_overflow), 0);
        chk("R1 reqs", {tx_req, rx_req}, 2'b10);
        chk("R1 valids", {tx_valid, rx_valid}, 0);

        cfg(1, 1, 0);
        // R2 R3 R4 R5 R9 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == 2'd2) begin
                chk("R3 R9 pop order", {tx_valid, tx_data}, {1'b1, VEC[i].d[7:0]});
                tx_ready = 1;
                tick();
            end else begin
                wr(VEC[i].op[0], VEC[i].d);
            end
            chk("R2 R3 R4 level", 32'(tx_level), 32'(VEC[i].lvl));
            chk("R5 tx_req four", 32'(tx_req), 32'(VEC[i].req));
            chk("R4 overflow", 32'(tx_overflow), 32'(VEC[i].ovf));
        end
        chk("R3 next word byte", 32'(tx_data), 32'h55);
        // R9 pop plus byte push same cycle
        tx_ready = 1; thr_we = 1; thr_word = 0; thr_data = 32'h77;
        tick();
        chk("R9 pop+push level", 32'(tx_level), 12);
        chk("R9 next head", 32'(tx_data), 32'h66);
        // R8 flush with write same cycle
        tx_flush = 1; thr_we = 1; thr_word = 1; thr_data = 32'h12345678;
        tick();
        chk("R8 flush level", 32'(tx_level), 0);
        chk("R8 flush clears overflow", 32'(tx_overflow), 0);
        chk("R8 flush valid", 32'(tx_valid), 0);
        // R5 ONE mode
        cfg(1, 0, 0);
        for (int k = 0; k < 4; k++) wr(1, 32'h01010101);
        chk("R5 one mode full", {tx_req, 5'(tx_level)}, {1'b0, 5'd16});
        tx_ready = 1;
        tick();
        chk("R5 one mode one free", {tx_req, 5'(tx_level)}, {1'b1, 5'd15});
        cfg(1, 1, 0);
        chk("R5 four mode one free", 32'(tx_req), 0);
        tx_flush = 1;
        tick();
        // R7 receive requests
        chk("R7 rx empty", 32'(rx_req), 0);
        rxpush(8'hA1);
        chk("R7 rx one", {rx_req, 5'(rx_level)}, {1'b1, 5'd1});
        cfg(1, 1, 1);
        chk("R7 rx four with one", 32'(rx_req), 0);
        rxpush(8'hA2); rxpush(8'hA3);
        chk("R7 rx four with three", 32'(rx_req), 0);
        rxpush(8'hA4);
        chk("R7 rx four with four", 32'(rx_req), 1);
        chk("R9 rx head", {rx_valid, rx_data}, {1'b1, 8'hA1});
        rx_ready = 1;
        tick();
        chk("R9 rx pop", {rx_req, 5'(rx_level), rx_data}, {1'b0, 5'd3, 8'hA2});
        // R8 rx clear with push same cycle
        rx_clear = 1; rx_in_valid = 1; rx_in_data = 8'hEE;
        tick();
        chk("R8 rx clear", {rx_valid, 5'(rx_level)}, 0);
        // R6 single-character mode
        cfg(0, 1, 1);
        chk("R6 single empty req", 32'(tx_req), 1);
        wr(1, 32'hAABBCCDD);
        chk("R6 single word low byte", {5'(tx_level), tx_data}, {5'd1, 8'hDD});
        chk("R6 single full req", {tx_req, tx_overflow}, 2'b00);
        wr(0, 32'h55);
        chk("R6 R4 single second dropped", {5'(tx_level), tx_data, tx_overflow}, {5'd1, 8'hDD, 1'b1});
        // R11 receive at capacity
        rxpush(8'hB1); rxpush(8'hB2);
        chk("R11 rx dropped", {5'(rx_level), rx_data}, {5'd1, 8'hB1});
        chk("R7 single rx req ignores mode", 32'(rx_req), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule